// File: doc/BRIEF.md
# Data-Space Address Generator

This block turns a load/store command from a small 8-bit core into an effective data-space address. It then steers the access to one of three regions. The data space is flat. The general registers sit at the bottom, the I/O registers follow, and the internal SRAM comes last. A single 16-bit address therefore reaches all three regions, and the block sends each region an address relative to that region's own start.

The block keeps its own copy of three 16-bit pointers, called X, Y and Z. These are the register pairs at general-register indices 26/27, 28/29 and 30/31, with the lower index as the low byte. It tracks the core's register writes to keep the copy current. An access that auto-modifies a pointer reports the new pointer value on a write-back port in the same cycle as the memory request. The block updates its own copy at the following clock edge. The address, region and write-back outputs are combinational from the command and the stored pointers.

Top module: `dsag_top`

## Requirements
- R1: An effective address below 0x20 asserts `sel_rf` with `loc_addr` equal to the address. An address from 0x20 to 0x5F asserts `sel_io` with `loc_addr` equal to the address minus 0x20.
- R2: An address from 0x60 to 0x60+SRAM_BYTES-1 asserts `sel_sram` with `loc_addr` equal to the address minus 0x60. Any higher address asserts `out_of_range` and no region select. At most one of the four outputs is high at a time.
- R3: Mode code 0 (direct) uses the full 16-bit `cmd_addr` as the effective address.
- R4: Mode code 1 (indirect) uses the selected pointer as the address. The pointer select codes are 0 for X, 1 for Y and 2 for Z.
- R5: Mode code 2 (displacement) adds the unsigned 6-bit `cmd_disp` (0 to 63) to Y or Z. With X, or with pointer code 3, this mode raises `cmd_err` and issues no request.
- R6: Mode code 3 (pre-decrement) uses pointer−1 as the address. It asserts `wb_en` with `wb_val` equal to that address in the same cycle. The stored pointer holds the new value from the next cycle.
- R7: Mode code 4 (post-increment) uses the pointer as the address. It asserts `wb_en` with `wb_val` equal to pointer+1, and the stored pointer takes that value.
- R8: Pointer arithmetic and displacement sums wrap modulo 2^16. For example, 0x0000−1 gives 0xFFFF, and 0xFFFF+1 gives 0x0000.
- R9: A register write (`rf_we`) to index 26..31 loads the matching pointer byte (even index = low byte, X/Y/Z in ascending order). Writes to other indices leave the pointers unchanged. A write-back to the same pointer in the same cycle takes precedence.
- R10: With `cmd_valid` low, there is no request, no write-back and no pointer change. Mode codes 5 to 7, and pointer code 3 in modes 1, 3 and 4, raise `cmd_err` with no request.
- R11: After reset all three pointers read as 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_mode | input | 3 | Addressing mode code |
| cmd_ptr | input | 2 | Pointer select (0 X, 1 Y, 2 Z) |
| cmd_disp | input | 6 | Unsigned displacement |
| cmd_addr | input | 16 | Direct address |
| rf_we | input | 1 | Core register write strobe |
| rf_idx | input | 5 | Core register write index |
| rf_wdata | input | 8 | Core register write data |
| req_valid | output | 1 | Memory request |
| eff_addr | output | 16 | Effective data-space address |
| sel_rf | output | 1 | Register-file region select |
| sel_io | output | 1 | I/O region select |
| sel_sram | output | 1 | SRAM region select |
| out_of_range | output | 1 | Address beyond SRAM end |
| loc_addr | output | LOC_W | Address relative to the region start |
| cmd_err | output | 1 | Illegal mode/pointer combination |
| wb_en | output | 1 | Pointer write-back strobe |
| wb_ptr | output | 2 | Pointer being written back |
| wb_val | output | 16 | New pointer value |

## Verification
A corrupted stored pointer has no effect at the ports until an indirect command reads it. At that point the bad value shows in `eff_addr` in the same cycle, and it also shifts the region select and `loc_addr`. A post-increment or pre-decrement that fails to write back shows up one cycle later, on the next indirect access through the same pointer. A wrong region bound shows up only on the boundary addresses, so the bench probes each edge from both sides.

// File: rtl/dsag_pkg.sv
package dsag_pkg;
   localparam int AW = 16;

   localparam logic [2:0] M_DIRECT  = 3'd0;
   localparam logic [2:0] M_IND     = 3'd1;
   localparam logic [2:0] M_DISP    = 3'd2;
   localparam logic [2:0] M_PREDEC  = 3'd3;
   localparam logic [2:0] M_POSTINC = 3'd4;

   localparam logic [1:0] P_X = 2'd0;
   localparam logic [1:0] P_Y = 2'd1;
   localparam logic [1:0] P_Z = 2'd2;

   localparam logic [AW-1:0] IO_BASE   = 16'h0020;
   localparam logic [AW-1:0] SRAM_BASE = 16'h0060;
endpackage

// File: rtl/dsag_ptr_file.sv
module dsag_ptr_file
   import dsag_pkg::*;
#(
   parameter int NPTR     = 3,
   parameter int IDX_BASE = 26
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rf_we,
   input  logic [4:0]         rf_idx,
   input  logic [7:0]         rf_wdata,
   input  logic               wb_en,
   input  logic [1:0]         wb_ptr,
   input  logic [AW-1:0]      wb_val,
   output logic [NPTR*AW-1:0] ptrs
);
   for (genvar g = 0; g < NPTR; g++) begin : g_ptr
      localparam logic [4:0] LO_IDX = 5'(IDX_BASE + 2*g);
      localparam logic [4:0] HI_IDX = 5'(IDX_BASE + 2*g + 1);
      localparam logic [1:0] SEL    = 2'(g);
      logic [AW-1:0] p_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            p_q <= '0;
         else if (wb_en && wb_ptr == SEL)
            p_q <= wb_val;
         else if (rf_we && rf_idx == LO_IDX)
            p_q[7:0] <= rf_wdata;
         else if (rf_we && rf_idx == HI_IDX)
            p_q[15:8] <= rf_wdata;
      end

      assign ptrs[g*AW +: AW] = p_q;
   end
endmodule

// File: rtl/dsag_agu.sv
module dsag_agu
   import dsag_pkg::*;
(
   input  logic [2:0]      cmd_mode,
   input  logic [1:0]      cmd_ptr,
   input  logic [5:0]      cmd_disp,
   input  logic [AW-1:0]   cmd_addr,
   input  logic [3*AW-1:0] ptrs,
   output logic [AW-1:0]   eff,
   output logic            bad,
   output logic            wb_need,
   output logic [AW-1:0]   wb_next
);
   logic [AW-1:0] base;
   logic          ptr_ok;

   always_comb begin
      ptr_ok = (cmd_ptr != 2'd3);
      case (cmd_ptr)
         P_X:     base = ptrs[0*AW +: AW];
         P_Y:     base = ptrs[1*AW +: AW];
         P_Z:     base = ptrs[2*AW +: AW];
         default: base = '0;
      endcase
   end

   always_comb begin
      eff     = '0;
      bad     = 1'b0;
      wb_need = 1'b0;
      wb_next = '0;
      case (cmd_mode)
         M_DIRECT: eff = cmd_addr;
         M_IND: begin
            eff = base;
            bad = !ptr_ok;
         end
         M_DISP: begin
            eff = base + {10'd0, cmd_disp};
            bad = !ptr_ok || (cmd_ptr == P_X);
         end
         M_PREDEC: begin
            eff     = base - 16'd1;
            bad     = !ptr_ok;
            wb_need = 1'b1;
            wb_next = base - 16'd1;
         end
         M_POSTINC: begin
            eff     = base;
            bad     = !ptr_ok;
            wb_need = 1'b1;
            wb_next = base + 16'd1;
         end
         default: bad = 1'b1;
      endcase
   end
endmodule

// File: rtl/dsag_region.sv
module dsag_region
   import dsag_pkg::*;
#(
   parameter int SRAM_BYTES = 128,
   parameter int LOC_W      = $clog2(SRAM_BYTES)
) (
   input  logic             en,
   input  logic [AW-1:0]    eff,
   output logic             sel_rf,
   output logic             sel_io,
   output logic             sel_sram,
   output logic             oor,
   output logic [LOC_W-1:0] loc
);
   localparam logic [AW-1:0] SRAM_LAST = SRAM_BASE + AW'(SRAM_BYTES - 1);

   logic in_rf, in_io, in_sram;
   logic [AW-1:0] off_io, off_sram;

   always_comb begin
      in_rf    = eff < IO_BASE;
      in_io    = !in_rf && (eff < SRAM_BASE);
      in_sram  = (eff >= SRAM_BASE) && (eff <= SRAM_LAST);
      off_io   = eff - IO_BASE;
      off_sram = eff - SRAM_BASE;
      sel_rf   = en && in_rf;
      sel_io   = en && in_io;
      sel_sram = en && in_sram;
      oor      = en && (eff > SRAM_LAST);
      if (in_rf)
         loc = eff[LOC_W-1:0];
      else if (in_io)
         loc = off_io[LOC_W-1:0];
      else if (in_sram)
         loc = off_sram[LOC_W-1:0];
      else
         loc = '0;
   end
endmodule

// File: rtl/dsag_top.sv
module dsag_top
   import dsag_pkg::*;
#(
   parameter int SRAM_BYTES = 128,
   parameter int LOC_W      = $clog2(SRAM_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [2:0]       cmd_mode,
   input  logic [1:0]       cmd_ptr,
   input  logic [5:0]       cmd_disp,
   input  logic [15:0]      cmd_addr,
   input  logic             rf_we,
   input  logic [4:0]       rf_idx,
   input  logic [7:0]       rf_wdata,
   output logic             req_valid,
   output logic [15:0]      eff_addr,
   output logic             sel_rf,
   output logic             sel_io,
   output logic             sel_sram,
   output logic             out_of_range,
   output logic [LOC_W-1:0] loc_addr,
   output logic             cmd_err,
   output logic             wb_en,
   output logic [1:0]       wb_ptr,
   output logic [15:0]      wb_val
);
   if (SRAM_BYTES != 128 && SRAM_BYTES != 256 && SRAM_BYTES != 512) begin : g_bad_size
      $error("dsag_top: SRAM_BYTES must be 128, 256 or 512");
   end
   if (LOC_W < 7) begin : g_bad_locw
      $error("dsag_top: LOC_W too narrow for the I/O and SRAM offsets");
   end

   logic [3*AW-1:0] ptrs;
   logic            bad, wb_need;
   logic [AW-1:0]   wb_next;

   dsag_ptr_file #(.NPTR(3), .IDX_BASE(26)) u_ptrs (
      .clk(clk), .rst_n(rst_n),
      .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata),
      .wb_en(wb_en), .wb_ptr(wb_ptr), .wb_val(wb_val),
      .ptrs(ptrs)
   );

   dsag_agu u_agu (
      .cmd_mode(cmd_mode), .cmd_ptr(cmd_ptr), .cmd_disp(cmd_disp),
      .cmd_addr(cmd_addr), .ptrs(ptrs),
      .eff(eff_addr), .bad(bad), .wb_need(wb_need), .wb_next(wb_next)
   );

   assign req_valid = cmd_valid && !bad;
   assign cmd_err   = cmd_valid && bad;
   assign wb_en     = req_valid && wb_need;
   assign wb_ptr    = cmd_ptr;
   assign wb_val    = wb_next;

   dsag_region #(.SRAM_BYTES(SRAM_BYTES), .LOC_W(LOC_W)) u_region (
      .en(req_valid), .eff(eff_addr),
      .sel_rf(sel_rf), .sel_io(sel_io), .sel_sram(sel_sram),
      .oor(out_of_range), .loc(loc_addr)
   );
endmodule

// File: rtl/dsag_chk.sv
module dsag_chk
   import dsag_pkg::*;
#(
   parameter int SRAM_BYTES = 128,
   parameter int LOC_W      = $clog2(SRAM_BYTES)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [2:0]       cmd_mode,
   input logic [1:0]       cmd_ptr,
   input logic [15:0]      cmd_addr,
   input logic             rf_we,
   input logic             req_valid,
   input logic [15:0]      eff_addr,
   input logic             sel_rf,
   input logic             sel_io,
   input logic             sel_sram,
   input logic             out_of_range,
   input logic [LOC_W-1:0] loc_addr,
   input logic             cmd_err,
   input logic             wb_en,
   input logic [15:0]      wb_val
);
   localparam logic [15:0] LAST = 16'h0060 + 16'(SRAM_BYTES - 1);
   logic [15:0] sram_off;
   assign sram_off = eff_addr - 16'h0060;

   assert_single_region_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel_rf, sel_io, sel_sram, out_of_range}));

   assert_rf_local_R1: assert property (@(posedge clk) disable iff (!rst_n)
      sel_rf |-> (eff_addr < 16'h0020) && (loc_addr == eff_addr[LOC_W-1:0]));

   assert_sram_local_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_sram |-> (eff_addr >= 16'h0060) && (eff_addr <= LAST) && (loc_addr == sram_off[LOC_W-1:0]));

   assert_oor_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_of_range |-> (eff_addr > LAST) && req_valid);

   assert_direct_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && cmd_mode == M_DIRECT) |-> eff_addr == cmd_addr);

   assert_disp_x_rejected_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_mode == M_DISP && cmd_ptr == P_X) |-> cmd_err && !req_valid);

   assert_wb_persists_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wb_en) && !$past(rf_we) && cmd_valid && cmd_mode == M_IND && cmd_ptr == $past(cmd_ptr))
      |-> eff_addr == $past(wb_val));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |-> !req_valid && !wb_en && !cmd_err);
endmodule

bind dsag_top dsag_chk #(.SRAM_BYTES(SRAM_BYTES), .LOC_W(LOC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
   .cmd_ptr(cmd_ptr), .cmd_addr(cmd_addr), .rf_we(rf_we),
   .req_valid(req_valid), .eff_addr(eff_addr), .sel_rf(sel_rf), .sel_io(sel_io),
   .sel_sram(sel_sram), .out_of_range(out_of_range), .loc_addr(loc_addr),
   .cmd_err(cmd_err), .wb_en(wb_en), .wb_val(wb_val)
);

// File: tb/sim_dsag_top.sv
`timescale 1ns/1ps
module sim_dsag_top;
   localparam int SRAM_BYTES = 128;
   localparam int LOC_W = $clog2(SRAM_BYTES);
   localparam int LAST = 96 + SRAM_BYTES - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [2:0] cmd_mode = '0;
   logic [1:0] cmd_ptr = '0;
   logic [5:0] cmd_disp = '0;
   logic [15:0] cmd_addr = '0;
   logic rf_we = 1'b0;
   logic [4:0] rf_idx = '0;
   logic [7:0] rf_wdata = '0;
   logic req_valid, sel_rf, sel_io, sel_sram, out_of_range, cmd_err, wb_en;
   logic [15:0] eff_addr, wb_val;
   logic [LOC_W-1:0] loc_addr;
   logic [1:0] wb_ptr;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   dsag_top #(.SRAM_BYTES(SRAM_BYTES)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
      .cmd_ptr(cmd_ptr), .cmd_disp(cmd_disp), .cmd_addr(cmd_addr),
      .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata),
      .req_valid(req_valid), .eff_addr(eff_addr), .sel_rf(sel_rf), .sel_io(sel_io),
      .sel_sram(sel_sram), .out_of_range(out_of_range), .loc_addr(loc_addr),
      .cmd_err(cmd_err), .wb_en(wb_en), .wb_ptr(wb_ptr), .wb_val(wb_val)
   );

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // region code 0 rf, 1 io, 2 sram, 3 out of range
   function automatic int exp_region(int e);
      if (e < 32) return 0;
      else if (e < 96) return 1;
      else if (e <= LAST) return 2;
      else return 3;
   endfunction

   function automatic int exp_loc(int e);
      case (exp_region(e))
         0: return e;
         1: return e - 32;
         2: return e - 96;
         default: return 0;
      endcase
   endfunction

   // drive a command at a falling edge; outputs settle combinationally
   task automatic drive(logic [2:0] m, logic [1:0] p, logic [5:0] d, logic [15:0] a);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_mode = m; cmd_ptr = p; cmd_disp = d; cmd_addr = a;
      #1;
   endtask

   task automatic release_cmd();
      @(posedge clk); #1;
      cmd_valid = 1'b0;
   endtask

   task automatic check_access(string tag, int exp_eff);
      int r;
      r = exp_region(exp_eff);
      chk({tag, " req"}, int'(req_valid), 1);
      chk({tag, " eff"}, int'(eff_addr), exp_eff);
      chk({tag, " region"}, int'({out_of_range, sel_sram, sel_io, sel_rf}), 1 << r);
      if (r != 3) chk({tag, " loc"}, int'(loc_addr), exp_loc(exp_eff));
   endtask

   task automatic rf_write(int idx, int val);
      @(negedge clk);
      rf_we = 1'b1; rf_idx = 5'(idx); rf_wdata = 8'(val);
      @(posedge clk); #1;
      rf_we = 1'b0;
   endtask

   task automatic set_ptr(int p, int val);
      rf_write(26 + 2*p, val & 8'hFF);
      rf_write(27 + 2*p, (val >> 8) & 8'hFF);
   endtask

   task automatic read_ptr(string tag, int p, int exp);
      drive(3'd1, 2'(p), 6'd0, 16'd0);
      chk({tag, " ptr"}, int'(eff_addr), exp);
      release_cmd();
   endtask

   task automatic t_reset();
      read_ptr("R11 X after reset", 0, 0);
      read_ptr("R11 Y after reset", 1, 0);
      read_ptr("R11 Z after reset", 2, 0);
   endtask

   task automatic t_direct_bounds();
      int probes[8] = '{'h00, 'h1F, 'h20, 'h5F, 'h60, LAST, LAST + 1, 'hFFFF};
      foreach (probes[i]) begin
         drive(3'd0, 2'd0, 6'd0, 16'(probes[i]));
         check_access($sformatf("R1 R2 R3 direct 0x%0h", probes[i]), probes[i]);
         release_cmd();
      end
   endtask

   task automatic t_indirect();
      set_ptr(0, 'h0045);
      set_ptr(1, 'h0100);
      set_ptr(2, 'h0012);
      drive(3'd1, 2'd0, 6'd0, 16'h0000); check_access("R4 indirect X", 'h0045); release_cmd();
      drive(3'd1, 2'd1, 6'd0, 16'h0000); check_access("R4 indirect Y", 'h0100); release_cmd();
      drive(3'd1, 2'd2, 6'd0, 16'h0000); check_access("R4 indirect Z", 'h0012); release_cmd();
   endtask

   task automatic t_disp();
      set_ptr(1, 'h0050);
      drive(3'd2, 2'd1, 6'd63, 16'h0000); check_access("R5 disp Y+63", 'h008F); release_cmd();
      set_ptr(2, 'hFFF0);
      drive(3'd2, 2'd2, 6'd32, 16'h0000); check_access("R5 R8 disp Z wrap", 'h0010); release_cmd();
      drive(3'd2, 2'd0, 6'd1, 16'h0000);
      chk("R5 disp X err", int'(cmd_err), 1);
      chk("R5 disp X no req", int'({req_valid, sel_rf, sel_io, sel_sram, out_of_range}), 0);
      release_cmd();
   endtask

   task automatic t_postinc();
      set_ptr(0, 'h005F);
      drive(3'd4, 2'd0, 6'd0, 16'h0000);
      check_access("R7 postinc addr", 'h005F);
      chk("R7 postinc wb_en", int'(wb_en), 1);
      chk("R7 postinc wb_ptr", int'(wb_ptr), 0);
      chk("R7 postinc wb_val", int'(wb_val), 'h0060);
      release_cmd();
      drive(3'd1, 2'd0, 6'd0, 16'h0000); check_access("R7 ptr after postinc", 'h0060); release_cmd();
      set_ptr(2, 'hFFFF);
      drive(3'd4, 2'd2, 6'd0, 16'h0000);
      chk("R8 postinc wrap wb_val", int'(wb_val), 0);
      release_cmd();
      read_ptr("R8 Z wrapped to zero", 2, 0);
   endtask

   task automatic t_predec();
      set_ptr(1, 'h0060);
      drive(3'd3, 2'd1, 6'd0, 16'h0000);
      check_access("R6 predec addr", 'h005F);
      chk("R6 predec wb_en", int'(wb_en), 1);
      chk("R6 predec wb_val", int'(wb_val), 'h005F);
      release_cmd();
      read_ptr("R6 Y after predec", 1, 'h005F);
      set_ptr(0, 'h0000);
      drive(3'd3, 2'd0, 6'd0, 16'h0000);
      check_access("R8 predec wrap", 'hFFFF);
      release_cmd();
      read_ptr("R8 X wrapped", 0, 'hFFFF);
   endtask

   task automatic t_rf_mirror();
      set_ptr(1, 'h1234);
      rf_write(26, 'hAB);
      read_ptr("R9 X low byte only", 0, 'hFFAB);
      read_ptr("R9 Y untouched by X write", 1, 'h1234);
      rf_write(25, 'h77);
      rf_write(3, 'h55);
      read_ptr("R9 index 25 ignored", 0, 'hFFAB);
      read_ptr("R9 index 3 ignored Y", 1, 'h1234);
      // write-back and register write to same pointer in one cycle
      set_ptr(2, 'h0040);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_mode = 3'd4; cmd_ptr = 2'd2;
      rf_we = 1'b1; rf_idx = 5'd30; rf_wdata = 8'h99;
      @(posedge clk); #1;
      cmd_valid = 1'b0; rf_we = 1'b0;
      read_ptr("R9 write-back wins", 2, 'h0041);
   endtask

   task automatic t_idle_illegal();
      set_ptr(0, 'h0070);
      @(negedge clk);
      cmd_valid = 1'b0; cmd_mode = 3'd4; cmd_ptr = 2'd0;
      #1;
      chk("R10 idle no req", int'(req_valid), 0);
      chk("R10 idle no wb", int'(wb_en), 0);
      @(posedge clk); #1;
      read_ptr("R10 idle ptr unchanged", 0, 'h0070);
      for (int m = 5; m < 8; m++) begin
         drive(3'(m), 2'd0, 6'd0, 16'h0000);
         chk($sformatf("R10 mode %0d err", m), int'(cmd_err), 1);
         chk($sformatf("R10 mode %0d no req", m), int'({req_valid, wb_en}), 0);
         release_cmd();
      end
      drive(3'd4, 2'd3, 6'd0, 16'h0000);
      chk("R10 ptr code 3 err", int'(cmd_err), 1);
      chk("R10 ptr code 3 no wb", int'({req_valid, wb_en}), 0);
      release_cmd();
      read_ptr("R10 X unchanged after rejects", 0, 'h0070);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_direct_bounds();
      t_indirect();
      t_disp();
      t_postinc();
      t_predec();
      t_rf_mirror();
      t_idle_illegal();
      done = 1;
      summary();
      $finish;
   end
endmodule